// File: doc/BRIEF.md
# Banked Parallel Register Port

This block is the target side of a parallel host port. A host reaches a byte-wide internal register file through a 6-bit address bus, an 8-bit bidirectional data bus, and separate active-low read and write strobes. The register contents are also driven out in parallel to the downstream logic that uses them.

The register space has a global region and a profile region. A 2-bit bank-select input picks one of four profile banks. An address in the profile region is treated as an offset into the selected bank. The same bus address therefore reaches a different physical register in each bank, for both reads and writes.

Writes are taken into the system clock domain. Both strobes pass through a two-flop synchroniser. A write commits on the synchronised release of the write strobe. Reads are combinational from the raw pins, so debug readback needs no clock round trip.

Top module: `regport_bank`

## Requirements
- R1: While reset is asserted, and after it is released, every register reads zero, `globalRegs` and `profileRegs` are all zero, and `collideErr` is low.
- R2: A write to an address from 0x00 to 0x0F stores the full data byte into global register `addr`. The value is visible on `globalRegs[8*addr+7 : 8*addr]` no later than 4 clock cycles after `wrN` rises. Address, data and bank select must be held from the fall of `wrN` until at least one clock edge before it rises.
- R3: Registers change only when a write strobe completes, and each strobe commits exactly one byte. Repeated writes to one address leave the last value.
- R4: A write to an address from 0x10 to 0x17 stores into profile entry `bankSel*8 + (addr-0x10)`, shown at `profileRegs[8*k+7 : 8*k]`. Entries in the other three banks are unchanged.
- R5: While `rdN` is low and `wrN` is high, `busData` carries the addressed register. A profile read uses the current `bankSel`.
- R6: While `wrN` is low, the block does not drive `busData`, so the host's write byte reaches the register unaltered.
- R7: Addresses 0x18 to 0x3F are unmapped. A read returns 0x00, and a write changes no register.
- R8: If both strobes are seen low together, `collideErr` is high for exactly one clock cycle, and the write strobe in progress commits nothing.
- R9: Global registers do not depend on `bankSel`. A global written under one bank reads back the same value under any other bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 6 | Host register address |
| busData | inout | 8 | Host data bus, driven by the block only during reads |
| rdN | input | 1 | Active-low read strobe |
| wrN | input | 1 | Active-low write strobe |
| bankSel | input | 2 | Profile bank select |
| collideErr | output | 1 | One-cycle pulse when both strobes are seen low together |
| globalRegs | output | 128 | Global registers, entry g at bits 8g+7:8g |
| profileRegs | output | 256 | Profile registers, entry k at bits 8k+7:8k |

## Verification
A wrong synchroniser or edge-detect state shows up as a missing, doubled or early commit. It is visible on the flat register outputs within four clocks of the strobe release. A wrong capture stage or bank decode stores the byte in the wrong entry, or stores a neighbouring value. The bench compares the whole register image against a model after every write, so such an error is caught at that write rather than at a later readback. A stale collision flag either leaves the error pulse high for a second cycle, or blocks a later write, which then fails to land.

// File: rtl/regport_pkg.sv
package regport_pkg;
  typedef struct packed {
    logic commit;
    logic errPulse;
  } ctrlStrobe_t;
endpackage

// File: rtl/regport_ctrl.sv
module regport_ctrl
  import regport_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrN,
  input  logic        rdN,
  output ctrlStrobe_t strobes
);
  logic [SYNC_STAGES-1:0] wrSync, rdSync;
  logic wrPrev, collidePrev, spoiled, errReg;
  logic wrSeen, rdSeen, collide, wrRise;

  assign wrSeen  = wrSync[SYNC_STAGES-1];
  assign rdSeen  = rdSync[SYNC_STAGES-1];
  assign collide = !wrSeen && !rdSeen;
  assign wrRise  = wrSeen && !wrPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrSync      <= '1;
      rdSync      <= '1;
      wrPrev      <= 1'b1;
      collidePrev <= 1'b0;
      spoiled     <= 1'b0;
      errReg      <= 1'b0;
    end else begin
      wrSync      <= {wrSync[SYNC_STAGES-2:0], wrN};
      rdSync      <= {rdSync[SYNC_STAGES-2:0], rdN};
      wrPrev      <= wrSeen;
      collidePrev <= collide;
      errReg      <= collide && !collidePrev;
      spoiled     <= wrRise ? 1'b0 : (spoiled || collide);
    end
  end

  always_comb begin
    strobes.commit   = wrRise && !spoiled;
    strobes.errPulse = errReg;
  end
endmodule

// File: rtl/regport_dp.sv
module regport_dp
  import regport_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 8,
  parameter int BANK_W     = 2,
  parameter int GLOBAL_CNT = 16,
  parameter int PROF_BASE  = 16,
  parameter int PROF_DEPTH = 8,
  parameter int CAP_DEPTH  = 3
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic [ADDR_W-1:0]                     busAddr,
  input  logic [DATA_W-1:0]                     busWrData,
  input  logic [BANK_W-1:0]                     bankSel,
  input  ctrlStrobe_t                           strobes,
  output logic [DATA_W-1:0]                     rdData,
  output logic [GLOBAL_CNT*DATA_W-1:0]          globalFlat,
  output logic [(PROF_DEPTH<<BANK_W)*DATA_W-1:0] profileFlat
);
  localparam int NUM_BANKS = 1 << BANK_W;
  localparam int PROF_CNT  = NUM_BANKS * PROF_DEPTH;
  localparam int OFF_W     = $clog2(PROF_DEPTH);
  localparam int GIDX_W    = $clog2(GLOBAL_CNT);
  localparam logic [ADDR_W-1:0] PROF_BASE_A = ADDR_W'(PROF_BASE);

  function automatic logic inGlobal(input logic [ADDR_W-1:0] a);
    return int'(a) < GLOBAL_CNT;
  endfunction

  function automatic logic inProf(input logic [ADDR_W-1:0] a);
    return (int'(a) >= PROF_BASE) && (int'(a) < PROF_BASE + PROF_DEPTH);
  endfunction

  function automatic logic [OFF_W-1:0] profOff(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] d;
    d = a - PROF_BASE_A;
    return d[OFF_W-1:0];
  endfunction

  // capture pipeline aligned with the strobe synchroniser plus edge stage
  logic [ADDR_W-1:0] aPipe [CAP_DEPTH];
  logic [DATA_W-1:0] dPipe [CAP_DEPTH];
  logic [BANK_W-1:0] bPipe [CAP_DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < CAP_DEPTH; i++) begin
        aPipe[i] <= '0;
        dPipe[i] <= '0;
        bPipe[i] <= '0;
      end
    end else begin
      aPipe[0] <= busAddr;
      dPipe[0] <= busWrData;
      bPipe[0] <= bankSel;
      for (int i = 1; i < CAP_DEPTH; i++) begin
        aPipe[i] <= aPipe[i-1];
        dPipe[i] <= dPipe[i-1];
        bPipe[i] <= bPipe[i-1];
      end
    end
  end

  logic [ADDR_W-1:0] capAddr;
  logic [DATA_W-1:0] capData;
  logic [BANK_W-1:0] capBank;
  assign capAddr = aPipe[CAP_DEPTH-1];
  assign capData = dPipe[CAP_DEPTH-1];
  assign capBank = bPipe[CAP_DEPTH-1];

  logic [DATA_W-1:0] gReg [GLOBAL_CNT];
  logic [DATA_W-1:0] pReg [PROF_CNT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int g = 0; g < GLOBAL_CNT; g++) gReg[g] <= '0;
      for (int p = 0; p < PROF_CNT; p++)   pReg[p] <= '0;
    end else if (strobes.commit) begin
      if (inGlobal(capAddr))
        gReg[capAddr[GIDX_W-1:0]] <= capData;
      else if (inProf(capAddr))
        pReg[{capBank, profOff(capAddr)}] <= capData;
    end
  end

  always_comb begin
    rdData = '0;
    if (inGlobal(busAddr))
      rdData = gReg[busAddr[GIDX_W-1:0]];
    else if (inProf(busAddr))
      rdData = pReg[{bankSel, profOff(busAddr)}];
  end

  for (genvar g = 0; g < GLOBAL_CNT; g++) begin : gFlat
    assign globalFlat[g*DATA_W +: DATA_W] = gReg[g];
  end
  for (genvar p = 0; p < PROF_CNT; p++) begin : pFlat
    assign profileFlat[p*DATA_W +: DATA_W] = pReg[p];
  end
endmodule

// File: rtl/regport_bank.sv
module regport_bank
  import regport_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 8,
  parameter int BANK_W      = 2,
  parameter int GLOBAL_CNT  = 16,
  parameter int PROF_BASE   = 16,
  parameter int PROF_DEPTH  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic [ADDR_W-1:0]                      busAddr,
  inout  wire  [DATA_W-1:0]                      busData,
  input  logic                                   rdN,
  input  logic                                   wrN,
  input  logic [BANK_W-1:0]                      bankSel,
  output logic                                   collideErr,
  output logic [GLOBAL_CNT*DATA_W-1:0]           globalRegs,
  output logic [(PROF_DEPTH<<BANK_W)*DATA_W-1:0] profileRegs
);
  localparam int CAP_DEPTH = SYNC_STAGES + 1;

  ctrlStrobe_t       strobes;
  logic [DATA_W-1:0] rdData;
  logic              driveEn;

  regport_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrN(wrN), .rdN(rdN), .strobes(strobes)
  );

  regport_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W),
    .GLOBAL_CNT(GLOBAL_CNT), .PROF_BASE(PROF_BASE),
    .PROF_DEPTH(PROF_DEPTH), .CAP_DEPTH(CAP_DEPTH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busData),
    .bankSel(bankSel), .strobes(strobes), .rdData(rdData),
    .globalFlat(globalRegs), .profileFlat(profileRegs)
  );

  assign driveEn    = !rdN && wrN;
  assign busData    = driveEn ? rdData : {DATA_W{1'bz}};
  assign collideErr = strobes.errPulse;
endmodule

// File: rtl/regport_bank_chk.sv
module regport_bank_chk #(
  parameter int GFLAT_W = 128,
  parameter int PFLAT_W = 256
) (
  input logic               clk,
  input logic               rstN,
  input logic               commit,
  input logic               collideErr,
  input logic [GFLAT_W-1:0] globalFlat,
  input logic [PFLAT_W-1:0] profileFlat
);
  AST_ERR_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    collideErr |=> !collideErr); // R8

  AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    commit |=> !commit); // R3

  AST_GLOBAL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !commit |=> $stable(globalFlat)); // R2

  AST_PROFILE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !commit |=> $stable(profileFlat)); // R4

  AST_ONE_REGION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({!$stable(globalFlat), !$stable(profileFlat)})); // R3
endmodule

bind regport_bank regport_bank_chk #(
  .GFLAT_W(GLOBAL_CNT*DATA_W),
  .PFLAT_W((PROF_DEPTH<<BANK_W)*DATA_W)
) u_chk (
  .clk(clk), .rstN(rstN), .commit(strobes.commit),
  .collideErr(collideErr), .globalFlat(globalRegs), .profileFlat(profileRegs)
);

// File: tb/regport_bank_tb.sv
module regport_bank_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [5:0] busAddr = '0;
  logic rdN = 1'b1, wrN = 1'b1;
  logic [1:0] bankSel = '0;
  logic hostDrive = 1'b0;
  logic [7:0] hostData = '0;
  wire  [7:0] busData;
  logic collideErr;
  logic [127:0] globalRegs;
  logic [255:0] profileRegs;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] expG [16];
  logic [7:0] expP [32];

  assign busData = hostDrive ? hostData : 8'bz;

  regport_bank u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busData(busData),
    .rdN(rdN), .wrN(wrN), .bankSel(bankSel), .collideErr(collideErr),
    .globalRegs(globalRegs), .profileRegs(profileRegs)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic cmpImage(input string req);
    int bad = 0;
    for (int g = 0; g < 16; g++) if (globalRegs[g*8 +: 8] !== expG[g]) bad++;
    for (int p = 0; p < 32; p++) if (profileRegs[p*8 +: 8] !== expP[p]) bad++;
    chk(req, bad, 0);
  endtask

  task automatic hostWrite(input logic [5:0] a, input logic [7:0] d, input logic [1:0] b);
    @(negedge clk);
    busAddr = a; bankSel = b; hostData = d; hostDrive = 1'b1; wrN = 1'b0;
    waitN(3);
    wrN = 1'b1;
    waitN(1);
    hostDrive = 1'b0;
    waitN(4);
    if (a < 6'h10) expG[a[3:0]] = d;
    else if (a < 6'h18) expP[{b, a[2:0]}] = d;
  endtask

  task automatic hostRead(input logic [5:0] a, input logic [1:0] b, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; bankSel = b; rdN = 1'b0;
    @(negedge clk);
    d = busData;
    rdN = 1'b1;
  endtask

  task automatic testReset();
    chk("R1 globals zero", {31'd0, |globalRegs}, 0);
    chk("R1 profiles zero", {31'd0, |profileRegs}, 0);
    chk("R1 collideErr low", {31'd0, collideErr}, 0);
  endtask

  task automatic testGlobalWrite();
    logic [7:0] r;
    hostWrite(6'h00, 8'h5A, 2'd0);
    cmpImage("R2 write 0x00");
    hostWrite(6'h0F, 8'hFF, 2'd1);
    cmpImage("R2 write boundary 0x0F");
    hostRead(6'h0F, 2'd0, r);
    chk("R5 read global 0x0F", r, 8'hFF);
    hostRead(6'h00, 2'd3, r);
    chk("R9 global independent of bank", r, 8'h5A);
  endtask

  task automatic testRepeatWrite();
    hostWrite(6'h07, 8'h11, 2'd0);
    hostWrite(6'h07, 8'h22, 2'd0);
    hostWrite(6'h07, 8'h81, 2'd2);
    cmpImage("R3 last write wins");
    chk("R3 reg7 value", globalRegs[7*8 +: 8], 8'h81);
  endtask

  task automatic testProfileBanks();
    logic [7:0] r;
    for (int b = 0; b < 4; b++) begin
      hostWrite(6'h13, 8'hA0 + 8'(b), 2'(b));
      cmpImage("R4 bank write isolation");
    end
    hostWrite(6'h17, 8'hC3, 2'd2);
    chk("R4 entry 23", profileRegs[23*8 +: 8], 8'hC3);
    hostWrite(6'h10, 8'h3C, 2'd3);
    chk("R4 entry 24", profileRegs[24*8 +: 8], 8'h3C);
    for (int b = 0; b < 4; b++) begin
      hostRead(6'h13, 2'(b), r);
      chk("R5 banked readback", r, 8'hA0 + 8'(b));
    end
    hostRead(6'h17, 2'd1, r);
    chk("R5 other bank unwritten", r, 8'h00);
  endtask

  task automatic testWriteBusIntegrity();
    @(negedge clk);
    busAddr = 6'h05; bankSel = 2'd0; hostData = 8'h96; hostDrive = 1'b1; wrN = 1'b0;
    waitN(1);
    chk("R6 bus holds host byte", busData, 8'h96);
    waitN(2);
    wrN = 1'b1;
    waitN(1);
    hostDrive = 1'b0;
    waitN(4);
    expG[5] = 8'h96;
    cmpImage("R6 byte stored unaltered");
  endtask

  task automatic testUnmapped();
    logic [7:0] r;
    hostWrite(6'h18, 8'h77, 2'd0);
    hostWrite(6'h3F, 8'h66, 2'd3);
    cmpImage("R7 unmapped write ignored");
    hostRead(6'h18, 2'd0, r);
    chk("R7 read 0x18", r, 8'h00);
    hostRead(6'h2A, 2'd2, r);
    chk("R7 read 0x2A", r, 8'h00);
  endtask

  task automatic testCollision();
    int highs = 0;
    @(negedge clk);
    busAddr = 6'h02; bankSel = 2'd0; hostData = 8'hEE; hostDrive = 1'b1;
    wrN = 1'b0; rdN = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (collideErr) highs++;
    end
    wrN = 1'b1; rdN = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (collideErr) highs++;
      if (i == 0) hostDrive = 1'b0;
    end
    chk("R8 single error pulse", highs, 1);
    cmpImage("R8 colliding write dropped");
    hostWrite(6'h02, 8'h42, 2'd0);
    cmpImage("R8 next write lands");
  endtask

  initial begin
    for (int i = 0; i < 16; i++) expG[i] = '0;
    for (int i = 0; i < 32; i++) expP[i] = '0;
    waitN(2);
    testReset();
    rstN = 1'b1;
    waitN(2);
    testReset();
    testGlobalWrite();
    testRepeatWrite();
    testProfileBanks();
    testWriteBusIntegrity();
    testUnmapped();
    testCollision();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog R3 actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule